// File: doc/BRIEF.md
# Host Bridge Control Register File

This block holds the control words of a host bridge: power-on and general configuration, I/O and memory timing, address-map setup, GPIO data and enables, interrupt edge/steer/polarity, four mailboxes, cache control and timing words. It has 28 words of 32 bits. A word is selected by its byte offset divided by four, so the space covers offsets 0x00 to 0x6C. Most words are plain storage that software reads back. The functions these words control sit in other blocks, which take the stored values from here.

Three offsets have side effects:
- The interrupt enable word at 0x38 is changed only through the set word at 0x30, whose written value is ORed into it, and the clear word at 0x34, whose set bits clear it.
- The enable word and the interrupt status word at 0x3C cannot be written.
- A write to the general configuration word at 0x04 that moves bit 2 from 0 to 1 raises a one-cycle system reset request.

Requests come in over a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read answers on a valid/ready response channel one cycle after it is accepted. While a read response waits for `rsp_ready`, the response stays stable and `req_ready` is low, so back-pressure on the response stalls the request side.

Top module: `brg_ctrl_regs`

## Requirements
- R1: After reset, reads return 0xC40 at 0x00, 0x1384 at 0x04, 0x2BFF8010 at 0x08, 0x255E0091 at 0x0C, 0x6140 at 0x10, 0x1FF at 0x1C and 0x20, 0x8 at 0x68, 0x10000000 at 0x6C, and zero at every other offset from 0x00 to 0x6C.
- R2: At 0x00, 0x08 to 0x2C and 0x40 to 0x6C, a write stores the full 32-bit value and a later read returns it.
- R3: A write to 0x30 stores the value at 0x30 and ORs it into the enable word at 0x38.
- R4: A write to 0x34 stores the value at 0x34 and clears in the enable word at 0x38 every bit that is 1 in the value.
- R5: Writes to 0x38 and 0x3C change nothing. The status word at 0x3C reads zero.
- R6: A write to 0x04 always stores its value. If bit 2 of the stored word was 0 and bit 2 of the new value is 1, `sys_reset_req` is high for exactly the one cycle after the accepting edge.
- R7: A write to 0x04 that leaves bit 2 at 1, or that clears bit 2, raises no reset request.
- R8: Offsets 0x70 to 0xFC are undefined: reads return zero and writes change nothing.
- R9: A request is accepted when `req_valid` and `req_ready` are both high. The read data shows on `rsp_data` with `rsp_valid` high from the cycle after acceptance and is held unchanged until `rsp_ready` is high. While the response is held, `req_ready` is low.
- R10: The word index is `req_addr[7:2]`. `req_addr[1:0]` is ignored, because only full-word accesses exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset; bits [7:2] select the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 32 | Read data |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume the requester follows the channel rules. Once `req_valid` is raised, the request fields stay stable until the request is accepted, and `rsp_ready` is a plain level that takes the response whenever it is high. The stimulus drives every request at the falling edge. It holds a request until `req_ready` has been seen high at an accepting edge, and it drops `rsp_ready` only in one directed back-pressure test, so the inputs never leave those rules.

// File: rtl/brg_pkg.sv
package brg_pkg;

  localparam int unsigned DATA_W = 32;

  // word indices whose behaviour other logic depends on
  localparam int unsigned IDX_GENCFG = 1;
  localparam int unsigned IDX_EN_SET = 12;
  localparam int unsigned IDX_EN_CLR = 13;
  localparam int unsigned IDX_EN     = 14;
  localparam int unsigned IDX_STAT   = 15;
  localparam int unsigned SRST_BIT   = 2;

  typedef enum logic [2:0] {
    ACC_PLAIN = 3'd0,
    ACC_GEN   = 3'd1,
    ACC_SET   = 3'd2,
    ACC_CLR   = 3'd3,
    ACC_RO    = 3'd4,
    ACC_NONE  = 3'd5
  } acc_kind_e;

  function automatic logic [DATA_W-1:0] reset_word(input int unsigned idx);
    logic [DATA_W-1:0] v;
    case (idx)
      0:       v = 32'h0000_0C40;
      1:       v = 32'h0000_1384;
      2:       v = 32'h2BFF_8010;
      3:       v = 32'h255E_0091;
      4:       v = 32'h0000_6140;
      7:       v = 32'h0000_01FF;
      8:       v = 32'h0000_01FF;
      26:      v = 32'h0000_0008;
      27:      v = 32'h1000_0000;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/brg_addr_decode.sv
module brg_addr_decode
  import brg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 28,
  localparam int unsigned WADDR_W  = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [WADDR_W-1:0] widx,
  output logic               in_range,
  output acc_kind_e          kind
);

  logic [1:0] unused_byte_lane;
  assign unused_byte_lane = addr[1:0];   // R10: sub-word bits play no part

  assign widx     = addr[ADDR_W-1:2];
  assign in_range = (32'(widx) < NUM_WORDS);

  always_comb begin
    if (!in_range) begin
      kind = ACC_NONE;
    end else begin
      case (32'(widx))
        IDX_GENCFG:         kind = ACC_GEN;
        IDX_EN_SET:         kind = ACC_SET;
        IDX_EN_CLR:         kind = ACC_CLR;
        IDX_EN, IDX_STAT:   kind = ACC_RO;
        default:            kind = ACC_PLAIN;
      endcase
    end
  end

endmodule

// File: rtl/brg_intr_en.sv
module brg_intr_en #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (set_we) begin
      en_q <= en_q | wdata;
    end else if (clr_we) begin
      en_q <= en_q & ~wdata;
    end
  end

  AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en_q & $past(wdata)) == $past(wdata))
               && ((en_q & $past(en_q)) == $past(en_q)));  // R3

  AST_CLR_MASKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_q & $past(wdata)) == '0)
               && ((en_q | $past(en_q)) == $past(en_q)));  // R4

endmodule

// File: rtl/brg_soft_reset.sv
module brg_soft_reset (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_we,
  input  logic old_bit,
  input  logic new_bit,
  output logic pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
    end else begin
      pulse <= gen_we && !old_bit && new_bit;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);  // R6

endmodule

// File: rtl/brg_ctrl_regs.sv
module brg_ctrl_regs
  import brg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 28,
  localparam int unsigned WADDR_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              sys_reset_req
);

  logic [WADDR_W-1:0] widx;
  logic               in_range;
  acc_kind_e          kind;
  logic               acc, wr_acc, rd_acc;
  logic [DATA_W-1:0]  words [NUM_WORDS];
  logic [DATA_W-1:0]  en_q;
  logic [DATA_W-1:0]  rd_word;

  brg_addr_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) dec_i (
    .addr(req_addr), .widx(widx), .in_range(in_range), .kind(kind)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;

  brg_intr_en #(.DATA_W(DATA_W)) ien_i (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_acc && kind == ACC_SET),
    .clr_we(wr_acc && kind == ACC_CLR),
    .wdata(req_wdata), .en_q(en_q)
  );

  // storage: plain words as flops, enable from its unit, status tied to zero
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (i == IDX_EN) begin : g_en
      assign words[i] = en_q;
    end else if (i == IDX_STAT) begin : g_stat
      assign words[i] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= reset_word(i);
        end else if (wr_acc && in_range && widx == WADDR_W'(i)) begin
          q <= req_wdata;
        end
      end
      assign words[i] = q;
    end
  end

  brg_soft_reset srst_i (
    .clk(clk), .rst_n(rst_n),
    .gen_we(wr_acc && kind == ACC_GEN),
    .old_bit(words[IDX_GENCFG][SRST_BIT]),
    .new_bit(req_wdata[SRST_BIT]),
    .pulse(sys_reset_req)
  );

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (in_range && widx == WADDR_W'(k)) rd_word = words[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));  // R9

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);  // R9

  AST_RO_EN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && kind == ACC_RO) |=> $stable(en_q));  // R5

  AST_STAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    words[IDX_STAT] == '0);  // R5

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !in_range) |=> (rsp_data == '0));  // R8

  AST_GEN_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && kind == ACC_GEN) |=> (words[IDX_GENCFG] == $past(req_wdata)));  // R6

  AST_PULSE_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> words[IDX_GENCFG][SRST_BIT]);  // R6

endmodule

// File: tb/brg_ctrl_regs_tb.sv
module brg_ctrl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        sys_reset_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  brg_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sys_reset_req(sys_reset_req)
  );

  // fields: write(1) req(4) addr(8) wdata(32) expected(32)
  localparam int NV = 24;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 4'd2,  8'h40, 32'hDEADBEEF, 32'h0},          // R2 mailbox
    {1'b0, 4'd2,  8'h40, 32'h0,        32'hDEADBEEF},
    {1'b1, 4'd2,  8'h6C, 32'h12345678, 32'h0},          // R2 last word
    {1'b0, 4'd2,  8'h6C, 32'h0,        32'h12345678},
    {1'b1, 4'd2,  8'h10, 32'hCAFEF00D, 32'h0},
    {1'b0, 4'd2,  8'h10, 32'h0,        32'hCAFEF00D},
    {1'b1, 4'd3,  8'h30, 32'h000000F0, 32'h0},          // R3
    {1'b0, 4'd3,  8'h30, 32'h0,        32'h000000F0},
    {1'b0, 4'd3,  8'h38, 32'h0,        32'h000000F0},
    {1'b1, 4'd3,  8'h30, 32'h0F000003, 32'h0},
    {1'b0, 4'd3,  8'h38, 32'h0,        32'h0F0000F3},
    {1'b1, 4'd4,  8'h34, 32'h00000030, 32'h0},          // R4
    {1'b0, 4'd4,  8'h34, 32'h0,        32'h00000030},
    {1'b0, 4'd4,  8'h38, 32'h0,        32'h0F0000C3},
    {1'b1, 4'd5,  8'h38, 32'hFFFFFFFF, 32'h0},          // R5
    {1'b0, 4'd5,  8'h38, 32'h0,        32'h0F0000C3},
    {1'b1, 4'd5,  8'h3C, 32'hFFFFFFFF, 32'h0},
    {1'b0, 4'd5,  8'h3C, 32'h0,        32'h0},
    {1'b1, 4'd8,  8'h70, 32'hAAAA5555, 32'h0},          // R8
    {1'b0, 4'd8,  8'h70, 32'h0,        32'h0},
    {1'b0, 4'd8,  8'hFC, 32'h0,        32'h0},
    {1'b1, 4'd10, 8'h43, 32'h11223344, 32'h0},          // R10
    {1'b0, 4'd10, 8'h41, 32'h0,        32'h11223344},
    {1'b0, 4'd10, 8'h6E, 32'h0,        32'h12345678}
  };

  function automatic logic [31:0] dflt(input int i);
    case (i * 4)
      8'h00: return 32'h00000C40;
      8'h04: return 32'h00001384;
      8'h08: return 32'h2BFF8010;
      8'h0C: return 32'h255E0091;
      8'h10: return 32'h00006140;
      8'h1C: return 32'h000001FF;
      8'h20: return 32'h000001FF;
      8'h68: return 32'h00000008;
      8'h6C: return 32'h10000000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // returns at the falling edge after the accepting edge
  task automatic do_req(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R6 reset sys_reset_req", {31'b0, sys_reset_req}, 32'h0);

    // R1: every defined word holds its default
    for (int i = 0; i < 28; i++) begin
      do_req(1'b0, 8'(i * 4), 32'h0);
      chk($sformatf("R1 default at 0x%02h", i * 4), rsp_data, dflt(i));
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_req(VEC[v][76], VEC[v][71:64], VEC[v][63:32]);
      if (!VEC[v][76]) begin
        chk($sformatf("R%0d read 0x%02h", VEC[v][75:72], VEC[v][71:64]),
            rsp_data, VEC[v][31:0]);
      end
    end

    // R7: bit already 1, no pulse
    do_req(1'b1, 8'h04, 32'h00001384);
    chk("R7 rewrite with bit set", {31'b0, sys_reset_req}, 32'h0);
    // R7: clearing the bit, no pulse, value stored
    do_req(1'b1, 8'h04, 32'h00001380);
    chk("R7 clear bit", {31'b0, sys_reset_req}, 32'h0);
    do_req(1'b0, 8'h04, 32'h0);
    chk("R6 stored without pulse", rsp_data, 32'h00001380);
    // R6: 0 -> 1 gives one pulse cycle
    do_req(1'b1, 8'h04, 32'h00000004);
    chk("R6 pulse high", {31'b0, sys_reset_req}, 32'h1);
    @(negedge clk);
    chk("R6 pulse one cycle", {31'b0, sys_reset_req}, 32'h0);
    do_req(1'b1, 8'h04, 32'h00000004);
    chk("R7 second set no pulse", {31'b0, sys_reset_req}, 32'h0);

    // R9: response back-pressure
    rsp_ready = 1'b0;
    do_req(1'b0, 8'h40, 32'h0);
    held = rsp_data;
    chk("R9 read data", held, 32'h11223344);
    for (int c = 0; c < 3; c++) begin
      chk("R9 rsp_valid held", {31'b0, rsp_valid}, 32'h1);
      chk("R9 req_ready low", {31'b0, req_ready}, 32'h0);
      chk("R9 data stable", rsp_data, held);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 response taken", {31'b0, rsp_valid}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule